// File: doc/BRIEF.md
# Multi-Line Atomic Event Tracker

This block follows one multi-instruction atomic event on behalf of a single core. Memory operations that carry the event marker bit (locked loads and locked prefetches) enroll their cache-line addresses in a small tracking table. Plain stores issued while the event is open are kept in a commit buffer, one slot per tracked line. They stay invisible until the event closes.

Memory actions from other agents arrive on a snoop port, each tagged with the priority of the requester. When a snoop hits a tracked line, the two priorities decide the outcome. A strictly higher-priority requester kills the local event. Any other requester is refused with a deny response, and the event survives. The core can ask at any time whether the open event has already been killed.

The event closes with a locked store. If the event is still intact, every buffered line is presented on a wide visibility bus in one single cycle. If the event has been killed, nothing is presented, the buffer is discarded and a one-cycle fail pulse lets the core take its failure path.

Top module: `atomic_span_tracker`

## Requirements
- R1: After a synchronous active-low reset, `commit`, `fail`, `vis_valid`, `qry_ack` and `snp_deny` are all 0.
- R2: Operation kinds are encoded as 0 load, 1 prefetch, 2 store and 3 none. A locked load or locked prefetch opens an event if none is open and enrolls its line. Lines take slots 0, 1, 2 … in the order they are first enrolled. Touching a line that is already enrolled takes no new slot and raises no failure.
- R3: A locked load or prefetch of a distinct line when all NUM_LINES slots are in use kills the event. `fail` is 1 in the cycle after that operation.
- R4: Some operations on an open event kill it, with `fail` 1 in the next cycle. These are a store (plain or locked) to a line that is not enrolled, and a locked load or prefetch of a new line after the first plain store of the event.
- R5: A snoop whose line is enrolled, from a requester whose priority is strictly greater than `local_prio`, kills the event. `fail` is 1 in the next cycle and `snp_deny` stays 0.
- R6: A snoop whose line is enrolled, from a requester whose priority is less than or equal to `local_prio`, drives `snp_deny` to 1 in that same cycle and does not kill the event. A snoop to an unenrolled line, or one that arrives while no live event exists, gets `snp_deny` 0 and causes no failure.
- R7: In the cycle after `qry_valid`, `qry_ack` is 1. `qry_killed` is 1 exactly when the event had already been killed before the query cycle and has not yet been closed.
- R8: A locked store to an enrolled line of a live event drives `commit` and `vis_valid` in the next cycle, for that one cycle only. `vis_valid` bit i is set for every slot i written during the event. Slot i carries its line address and the most recent data stored to it, including the closing store's data.
- R9: A killed event presents nothing on the visibility bus and discards its buffered stores. The next event starts with an empty table and buffer.
- R10: Ordinary loads enroll nothing. A plain store while no event is open has no effect on any output.
- R11: If a killing snoop and the closing locked store fall in the same cycle, the kill wins: `fail` 1, `commit` 0 and `vis_valid` 0 in the next cycle.
- R12: A locked store closes a killed event silently, without a second fail pulse, and returns the block to idle. A locked store while no event is open raises `fail` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_prio | input | PRIO_W | Priority of the local thread |
| op_valid | input | 1 | Core memory operation present |
| op_kind | input | 2 | 0 load, 1 prefetch, 2 store, 3 none |
| op_locked | input | 1 | Event marker bit of the operation |
| op_addr | input | TAG_W | Cache-line address of the operation |
| op_data | input | DATA_W | Store data |
| snp_valid | input | 1 | Memory action by another agent |
| snp_addr | input | TAG_W | Cache-line address of the snoop |
| snp_prio | input | PRIO_W | Priority of the snooping agent |
| snp_deny | output | 1 | Snoop refused, same cycle |
| qry_valid | input | 1 | Interference query |
| qry_ack | output | 1 | Query answer valid |
| qry_killed | output | 1 | Event already killed |
| commit | output | 1 | One-cycle commit pulse |
| fail | output | 1 | One-cycle failure pulse |
| vis_valid | output | NUM_LINES | Per-slot visible-update flags |
| vis_addr | output | NUM_LINES*TAG_W | Per-slot line addresses |
| vis_data | output | NUM_LINES*DATA_W | Per-slot line data |

## Verification
Two functions can land in the same cycle. A snoop from a requester with higher priority can arrive in exactly the cycle that carries the closing locked store. The bench provokes this by driving both on one clock edge against a line that holds buffered data. The result passes only if the fail pulse appears and neither commit nor any visibility bit does. As the contrasting case, the same collision with a lower-priority requester must yield a same-cycle deny and a full commit carrying the closing store's data.

// File: rtl/atomic_span_pkg.sv
// Shared types for the atomic span tracker.
// Assumes: operation kind encoding is fixed and visible at the top ports.
package atomic_span_pkg;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'd0,
        OP_PREFETCH = 2'd1,
        OP_STORE    = 2'd2,
        OP_NONE     = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_TOUCH  = 2'd1,
        EV_UPDATE = 2'd2,
        EV_DEAD   = 2'd3
    } ev_state_e;

endpackage

// File: rtl/span_line_table.sv
// Tracking table of cache lines enrolled in the open atomic event.
// Each slot holds a valid bit, a line tag and a written flag. Two
// lookups run in parallel (core operation and snoop). Slots are filled
// lowest-first and only ever cleared all together.
// Assumes: alloc_i is never raised while full_o is set, and never for a
// tag that already hits.
module span_line_table #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 26,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [TAG_W-1:0]                  op_tag_i,
    input  logic [TAG_W-1:0]                  snp_tag_i,
    input  logic                              alloc_i,
    input  logic                              mark_i,
    input  logic [IDX_W-1:0]                  mark_idx_i,
    input  logic                              clear_i,
    output logic                              op_hit_o,
    output logic [IDX_W-1:0]                  op_idx_o,
    output logic                              snp_hit_o,
    output logic                              full_o,
    output logic [NUM_LINES-1:0]              written_o,
    output logic [NUM_LINES-1:0][TAG_W-1:0]   tags_o
);

    logic [NUM_LINES-1:0]            valid_q;
    logic [NUM_LINES-1:0]            written_q;
    logic [NUM_LINES-1:0][TAG_W-1:0] tag_q;
    logic [NUM_LINES-1:0]            op_match;
    logic [NUM_LINES-1:0]            snp_match;
    logic [IDX_W-1:0]                free_idx;

    // Per-slot comparators for both lookup ports.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        assign op_match[g]  = valid_q[g] && (tag_q[g] == op_tag_i);
        assign snp_match[g] = valid_q[g] && (tag_q[g] == snp_tag_i);
    end

    assign op_hit_o  = |op_match;
    assign snp_hit_o = |snp_match;
    assign full_o    = &valid_q;
    assign written_o = written_q;
    assign tags_o    = tag_q;

    // Encode the slot index matched by the core operation.
    always_comb begin
        op_idx_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (op_match[i]) op_idx_o = IDX_W'(i);
        end
    end

    // Pick the lowest free slot for the next enrollment.
    always_comb begin
        free_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (!valid_q[i]) free_idx = IDX_W'(i);
        end
    end

    // Slot state: bulk clear, enrollment and written marking.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            valid_q   <= '0;
            written_q <= '0;
            tag_q     <= '0;
        end else begin
            if (alloc_i) begin
                valid_q[free_idx] <= 1'b1;
                tag_q[free_idx]   <= op_tag_i;
            end
            if (mark_i) begin
                written_q[mark_idx_i] <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !full_o); // R3

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (valid_q == '0) && (written_q == '0)); // R9

endmodule

// File: rtl/span_store_buffer.sv
// Commit buffer: one data word per tracked slot, held invisible until a
// publish, which presents every written slot on the visibility bus in a
// single registered cycle. A write in the publish cycle is merged in.
// Assumes: written_i and tags_i come from the tracking table, and
// clear_i discards the held data.
module span_store_buffer #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 26,
    parameter int DATA_W    = 64,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [IDX_W-1:0]                  wr_idx_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    input  logic                              clear_i,
    input  logic                              publish_i,
    input  logic [NUM_LINES-1:0]              written_i,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]   tags_i,
    output logic [NUM_LINES-1:0]              vis_valid_o,
    output logic [NUM_LINES-1:0][TAG_W-1:0]   vis_tag_o,
    output logic [NUM_LINES-1:0][DATA_W-1:0]  vis_data_o
);

    logic [NUM_LINES-1:0][DATA_W-1:0] data_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_slot
        logic wr_hit;
        assign wr_hit = wr_en_i && (wr_idx_i == IDX_W'(g));

        // Hold the latest store to this slot; drop it on clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                data_q[g] <= '0;
            end else if (wr_hit) begin
                data_q[g] <= wr_data_i;
            end
        end

        // Present the slot for exactly one cycle when published.
        always_ff @(posedge clk) begin
            if (!rst_n || !publish_i) begin
                vis_valid_o[g] <= 1'b0;
                vis_tag_o[g]   <= '0;
                vis_data_o[g]  <= '0;
            end else begin
                vis_valid_o[g] <= written_i[g] || wr_hit;
                vis_tag_o[g]   <= tags_i[g];
                vis_data_o[g]  <= wr_hit ? wr_data_i : data_q[g];
            end
        end
    end

    AST_VIS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|vis_valid_o) |=> (vis_valid_o == '0)); // R8

endmodule

// File: rtl/span_event_ctrl.sv
// Event controller: classifies core operations and snoops, decides on
// enrollment, buffering, kill, deny, commit and abort, and answers the
// interference query.
// Assumes: table lookups (op_hit_i, snp_hit_i, full_i) are combinational
// views of the current table state.
module span_event_ctrl
    import atomic_span_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIO_W-1:0] local_prio_i,
    input  logic              op_valid_i,
    input  logic [1:0]        op_kind_i,
    input  logic              op_locked_i,
    input  logic              snp_valid_i,
    input  logic [PRIO_W-1:0] snp_prio_i,
    input  logic              qry_valid_i,
    input  logic              op_hit_i,
    input  logic              snp_hit_i,
    input  logic              full_i,
    output logic              alloc_o,
    output logic              buf_wr_o,
    output logic              clear_o,
    output logic              publish_o,
    output logic              snp_deny_o,
    output logic              qry_ack_o,
    output logic              qry_killed_o,
    output logic              commit_o,
    output logic              fail_o
);

    ev_state_e state_q, state_d;
    logic      is_touch, is_store, is_lk_store, is_pl_store;
    logic      live, snp_conflict, snp_kill, op_bad, kill;
    logic      fail_d, commit_d;

    // Classify the core operation.
    always_comb begin
        is_touch    = op_valid_i && op_locked_i &&
                      (op_kind_i == OP_LOAD || op_kind_i == OP_PREFETCH);
        is_store    = op_valid_i && (op_kind_i == OP_STORE);
        is_lk_store = is_store && op_locked_i;
        is_pl_store = is_store && !op_locked_i;
    end

    // Decide on snoop conflict and rule breaks by the local operation.
    always_comb begin
        live         = (state_q == EV_TOUCH) || (state_q == EV_UPDATE);
        snp_conflict = live && snp_valid_i && snp_hit_i;
        snp_kill     = snp_conflict && (snp_prio_i > local_prio_i);
        snp_deny_o   = snp_conflict && !(snp_prio_i > local_prio_i);
        op_bad       = (is_touch && !op_hit_i &&
                        (full_i || state_q == EV_UPDATE)) ||
                       (is_store && !op_hit_i);
        kill         = snp_kill || op_bad;
    end

    // Next-state and action decode for the event.
    always_comb begin
        state_d   = state_q;
        alloc_o   = 1'b0;
        buf_wr_o  = 1'b0;
        clear_o   = 1'b0;
        publish_o = 1'b0;
        fail_d    = 1'b0;
        commit_d  = 1'b0;
        case (state_q)
            EV_IDLE: begin
                if (is_touch) begin
                    alloc_o = 1'b1;
                    state_d = EV_TOUCH;
                end else if (is_lk_store) begin
                    fail_d = 1'b1;
                end
            end
            EV_TOUCH, EV_UPDATE: begin
                if (is_lk_store) begin
                    clear_o = 1'b1;
                    state_d = EV_IDLE;
                    if (kill) begin
                        fail_d = 1'b1;
                    end else begin
                        buf_wr_o  = 1'b1;
                        publish_o = 1'b1;
                        commit_d  = 1'b1;
                    end
                end else if (kill) begin
                    fail_d  = 1'b1;
                    clear_o = 1'b1;
                    state_d = EV_DEAD;
                end else if (is_pl_store) begin
                    buf_wr_o = 1'b1;
                    state_d  = EV_UPDATE;
                end else if (is_touch && !op_hit_i) begin
                    alloc_o = 1'b1;
                end
            end
            EV_DEAD: begin
                if (is_lk_store) state_d = EV_IDLE;
            end
            default: state_d = EV_IDLE;
        endcase
    end

    // Event state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    // Registered pulses and query answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_o       <= 1'b0;
            commit_o     <= 1'b0;
            qry_ack_o    <= 1'b0;
            qry_killed_o <= 1'b0;
        end else begin
            fail_o       <= fail_d;
            commit_o     <= commit_d;
            qry_ack_o    <= qry_valid_i;
            qry_killed_o <= qry_valid_i && (state_q == EV_DEAD);
        end
    end

    AST_QRY_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        qry_ack_o |-> $past(qry_valid_i)); // R7

    AST_COMMIT_NEEDS_LKST: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(op_valid_i && op_locked_i && op_kind_i == OP_STORE)); // R8

    AST_FAIL_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail_o && commit_o)); // R11

    AST_DENY_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_deny_o && !op_valid_i) |=> !fail_o); // R6

endmodule

// File: rtl/atomic_span_tracker.sv
// Top of the atomic span tracker: ties the tracking table, commit buffer
// and event controller together and flattens the visibility bus.
// Assumes: one core operation and one snoop at most per cycle; addresses
// are already cache-line addresses.
module atomic_span_tracker #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 26,
    parameter int DATA_W    = 64,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PRIO_W-1:0]             local_prio,
    input  logic                          op_valid,
    input  logic [1:0]                    op_kind,
    input  logic                          op_locked,
    input  logic [TAG_W-1:0]              op_addr,
    input  logic [DATA_W-1:0]             op_data,
    input  logic                          snp_valid,
    input  logic [TAG_W-1:0]              snp_addr,
    input  logic [PRIO_W-1:0]             snp_prio,
    output logic                          snp_deny,
    input  logic                          qry_valid,
    output logic                          qry_ack,
    output logic                          qry_killed,
    output logic                          commit,
    output logic                          fail,
    output logic [NUM_LINES-1:0]          vis_valid,
    output logic [NUM_LINES*TAG_W-1:0]    vis_addr,
    output logic [NUM_LINES*DATA_W-1:0]   vis_data
);

    logic                             op_hit, snp_hit, full;
    logic [IDX_W-1:0]                 op_idx;
    logic                             alloc, buf_wr, clear, publish;
    logic [NUM_LINES-1:0]             written;
    logic [NUM_LINES-1:0][TAG_W-1:0]  tags;
    logic [NUM_LINES-1:0][TAG_W-1:0]  vis_tag_p;
    logic [NUM_LINES-1:0][DATA_W-1:0] vis_data_p;

    span_line_table #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_tag_i   (op_addr),
        .snp_tag_i  (snp_addr),
        .alloc_i    (alloc),
        .mark_i     (buf_wr),
        .mark_idx_i (op_idx),
        .clear_i    (clear),
        .op_hit_o   (op_hit),
        .op_idx_o   (op_idx),
        .snp_hit_o  (snp_hit),
        .full_o     (full),
        .written_o  (written),
        .tags_o     (tags)
    );

    span_store_buffer #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (buf_wr),
        .wr_idx_i    (op_idx),
        .wr_data_i   (op_data),
        .clear_i     (clear),
        .publish_i   (publish),
        .written_i   (written),
        .tags_i      (tags),
        .vis_valid_o (vis_valid),
        .vis_tag_o   (vis_tag_p),
        .vis_data_o  (vis_data_p)
    );

    span_event_ctrl #(
        .PRIO_W (PRIO_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .local_prio_i (local_prio),
        .op_valid_i   (op_valid),
        .op_kind_i    (op_kind),
        .op_locked_i  (op_locked),
        .snp_valid_i  (snp_valid),
        .snp_prio_i   (snp_prio),
        .qry_valid_i  (qry_valid),
        .op_hit_i     (op_hit),
        .snp_hit_i    (snp_hit),
        .full_i       (full),
        .alloc_o      (alloc),
        .buf_wr_o     (buf_wr),
        .clear_o      (clear),
        .publish_o    (publish),
        .snp_deny_o   (snp_deny),
        .qry_ack_o    (qry_ack),
        .qry_killed_o (qry_killed),
        .commit_o     (commit),
        .fail_o       (fail)
    );

    assign vis_addr = vis_tag_p;
    assign vis_data = vis_data_p;

    AST_VIS_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|vis_valid) |-> commit); // R8

endmodule

// File: tb/tb_atomic_span_tracker.sv
`timescale 1ns/1ps
module tb_atomic_span_tracker;

    localparam int N  = 8;
    localparam int AW = 26;
    localparam int DW = 64;
    localparam int PW = 3;
    localparam logic [1:0] K_LD = 2'd0, K_PF = 2'd1, K_ST = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PW-1:0] local_prio = '0;
    logic op_valid = 1'b0;
    logic [1:0] op_kind = 2'd3;
    logic op_locked = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [PW-1:0] snp_prio = '0;
    logic qry_valid = 1'b0;
    logic snp_deny, qry_ack, qry_killed, commit, fail;
    logic [N-1:0] vis_valid;
    logic [N*AW-1:0] vis_addr;
    logic [N*DW-1:0] vis_data;

    int checks = 0;
    int errors = 0;
    logic deny_s;

    always #2 clk = ~clk;

    atomic_span_tracker dut (
        .clk(clk), .rst_n(rst_n), .local_prio(local_prio),
        .op_valid(op_valid), .op_kind(op_kind), .op_locked(op_locked),
        .op_addr(op_addr), .op_data(op_data),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_prio(snp_prio),
        .snp_deny(snp_deny), .qry_valid(qry_valid), .qry_ack(qry_ack),
        .qry_killed(qry_killed), .commit(commit), .fail(fail),
        .vis_valid(vis_valid), .vis_addr(vis_addr), .vis_data(vis_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic begin_cyc();
        @(negedge clk);
    endtask

    // Sample the same-cycle deny, then the registered outputs, then idle inputs.
    task automatic end_cyc();
        #1 deny_s = snp_deny;
        @(posedge clk);
        #1;
        op_valid = 1'b0; op_kind = 2'd3; op_locked = 1'b0;
        snp_valid = 1'b0; qry_valid = 1'b0;
    endtask

    task automatic set_op(input logic [1:0] k, input logic lk,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
        op_valid = 1'b1; op_kind = k; op_locked = lk; op_addr = a; op_data = d;
    endtask

    task automatic set_snp(input logic [AW-1:0] a, input logic [PW-1:0] p);
        snp_valid = 1'b1; snp_addr = a; snp_prio = p;
    endtask

    task automatic do_op(input logic [1:0] k, input logic lk,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        begin_cyc(); set_op(k, lk, a, d); end_cyc();
    endtask

    task automatic do_snp(input logic [AW-1:0] a, input logic [PW-1:0] p);
        begin_cyc(); set_snp(a, p); end_cyc();
    endtask

    task automatic do_qry();
        begin_cyc(); qry_valid = 1'b1; end_cyc();
    endtask

    task automatic t_reset();
        chk("R1 commit", 64'(commit), 0);
        chk("R1 fail", 64'(fail), 0);
        chk("R1 vis_valid", 64'(vis_valid), 0);
        chk("R1 qry_ack", 64'(qry_ack), 0);
        chk("R1 snp_deny", 64'(snp_deny), 0);
    endtask

    task automatic t_commit();
        local_prio = 3'd3;
        do_op(K_LD, 1'b1, 26'h100, '0);
        chk("R2 first touch no fail", 64'(fail), 0);
        do_op(K_PF, 1'b1, 26'h101, '0);
        do_op(K_LD, 1'b1, 26'h100, '0);
        chk("R2 duplicate touch no fail", 64'(fail), 0);
        do_op(K_LD, 1'b0, 26'h105, '0);
        do_snp(26'h101, 3'd3);
        chk("R6 equal prio deny", 64'(deny_s), 1);
        chk("R6 equal prio no fail", 64'(fail), 0);
        do_snp(26'h101, 3'd1);
        chk("R6 lower prio deny", 64'(deny_s), 1);
        do_snp(26'h105, 3'd7);
        chk("R10 plain load line untracked", 64'(deny_s), 0);
        chk("R10 plain load line no fail", 64'(fail), 0);
        do_qry();
        chk("R7 ack", 64'(qry_ack), 1);
        chk("R7 live not killed", 64'(qry_killed), 0);
        do_op(K_ST, 1'b0, 26'h100, 64'hAAAA);
        do_op(K_ST, 1'b0, 26'h100, 64'hBBBB);
        chk("R8 no early commit", 64'(commit), 0);
        do_op(K_ST, 1'b1, 26'h101, 64'hCCCC);
        chk("R8 commit", 64'(commit), 1);
        chk("R8 fail low", 64'(fail), 0);
        chk("R8 vis_valid", 64'(vis_valid), 64'h3);
        chk("R8 slot0 addr", 64'(vis_addr[0*AW +: AW]), 64'h100);
        chk("R8 slot0 latest data", vis_data[0*DW +: DW], 64'hBBBB);
        chk("R8 slot1 addr", 64'(vis_addr[1*AW +: AW]), 64'h101);
        chk("R8 slot1 closing data", vis_data[1*DW +: DW], 64'hCCCC);
        begin_cyc(); end_cyc();
        chk("R8 one-cycle commit", 64'(commit), 0);
        chk("R8 one-cycle vis", 64'(vis_valid), 0);
        do_op(K_ST, 1'b0, 26'h103, 64'h1);
        chk("R10 idle plain store no fail", 64'(fail), 0);
        chk("R10 idle plain store no commit", 64'(commit), 0);
        do_snp(26'h100, 3'd0);
        chk("R6 idle snoop no deny", 64'(deny_s), 0);
    endtask

    task automatic t_kill();
        local_prio = 3'd2;
        do_op(K_LD, 1'b1, 26'h200, '0);
        do_op(K_LD, 1'b1, 26'h201, '0);
        do_op(K_ST, 1'b0, 26'h200, 64'hDEAD);
        do_snp(26'h201, 3'd5);
        chk("R5 higher prio no deny", 64'(deny_s), 0);
        chk("R5 kill fail pulse", 64'(fail), 1);
        chk("R9 no vis on kill", 64'(vis_valid), 0);
        do_qry();
        chk("R5 pulse one cycle", 64'(fail), 0);
        chk("R7 killed", 64'(qry_killed), 1);
        do_snp(26'h200, 3'd0);
        chk("R6 dead snoop no deny", 64'(deny_s), 0);
        do_op(K_ST, 1'b1, 26'h201, 64'h5);
        chk("R12 silent close no fail", 64'(fail), 0);
        chk("R12 silent close no commit", 64'(commit), 0);
        do_op(K_LD, 1'b1, 26'h201, '0);
        do_op(K_ST, 1'b1, 26'h201, 64'hE0E0);
        chk("R9 fresh event commit", 64'(commit), 1);
        chk("R9 only new slot", 64'(vis_valid), 64'h1);
        chk("R9 slot0 addr", 64'(vis_addr[0*AW +: AW]), 64'h201);
        chk("R9 slot0 data", vis_data[0*DW +: DW], 64'hE0E0);
    endtask

    task automatic t_overflow();
        local_prio = 3'd4;
        for (int i = 0; i < N; i++) begin
            do_op(K_LD, 1'b1, AW'(26'h300 + i), '0);
            chk("R2 fill no fail", 64'(fail), 0);
        end
        do_op(K_PF, 1'b1, 26'h303, '0);
        chk("R2 retouch when full no fail", 64'(fail), 0);
        do_op(K_LD, 1'b1, 26'h3FF, '0);
        chk("R3 ninth line fails", 64'(fail), 1);
        do_qry();
        chk("R3 killed after overflow", 64'(qry_killed), 1);
        do_op(K_ST, 1'b1, 26'h300, 64'h9);
        chk("R12 close after overflow", 64'(fail), 0);
        chk("R3 no commit", 64'(commit), 0);
    endtask

    task automatic t_unreg();
        local_prio = 3'd4;
        do_op(K_LD, 1'b1, 26'h400, '0);
        do_op(K_ST, 1'b0, 26'h401, 64'h1);
        chk("R4 store to unenrolled line", 64'(fail), 1);
        do_op(K_ST, 1'b1, 26'h400, 64'h1);
        chk("R4 no commit", 64'(commit), 0);
        do_op(K_LD, 1'b1, 26'h400, '0);
        do_op(K_ST, 1'b0, 26'h400, 64'h2);
        do_op(K_LD, 1'b1, 26'h402, '0);
        chk("R4 touch after update", 64'(fail), 1);
        do_op(K_ST, 1'b1, 26'h400, 64'h3);
        chk("R4 closed without commit", 64'(commit), 0);
        do_op(K_LD, 1'b1, 26'h400, '0);
        do_op(K_ST, 1'b1, 26'h403, 64'h4);
        chk("R4 locked store unenrolled", 64'(fail), 1);
        chk("R4 locked store no commit", 64'(commit), 0);
        do_qry();
        chk("R12 idle after failed close", 64'(qry_killed), 0);
    endtask

    task automatic t_collide();
        local_prio = 3'd1;
        do_op(K_LD, 1'b1, 26'h500, '0);
        do_op(K_ST, 1'b0, 26'h500, 64'h77);
        begin_cyc(); set_op(K_ST, 1'b1, 26'h500, 64'h88); set_snp(26'h500, 3'd4); end_cyc();
        chk("R11 kill wins fail", 64'(fail), 1);
        chk("R11 kill wins no commit", 64'(commit), 0);
        chk("R11 kill wins no vis", 64'(vis_valid), 0);
        do_qry();
        chk("R11 back to idle", 64'(qry_killed), 0);
        do_op(K_LD, 1'b1, 26'h500, '0);
        begin_cyc(); set_op(K_ST, 1'b1, 26'h500, 64'h99); set_snp(26'h500, 3'd0); end_cyc();
        chk("R6 collide low prio deny", 64'(deny_s), 1);
        chk("R8 collide low prio commit", 64'(commit), 1);
        chk("R8 collide data", vis_data[0*DW +: DW], 64'h99);
    endtask

    task automatic t_stray();
        do_op(K_ST, 1'b1, 26'h600, 64'h1);
        chk("R12 stray locked store fails", 64'(fail), 1);
        begin_cyc(); end_cyc();
        chk("R12 stray pulse one cycle", 64'(fail), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_commit();
        t_kill();
        t_overflow();
        t_unreg();
        t_collide();
        t_stray();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule